// File: doc/BRIEF.md
# Serial Parity-Checking Receiver

This block collects a serial word one bit per rising edge of a dedicated shift clock. Each word is eight bits long. The first seven bits that arrive are payload and the eighth is the parity bit that the sender attached. When the eighth bit lands, the receiver latches the seven payload bits and the received parity bit. It recomputes parity over the payload as the exclusive-OR of the payload bits, so the result is 1 when the payload holds an odd number of ones. It raises an error flag when the computed and received parity bits differ.

Bits move through a shift-right register. Each new bit enters at the most significant position. After eight shifts the first payload bit sits at bit 0 and the parity bit sits at bit 7. A modulo-eight bit counter marks the end of each word.

The latched outputs change only on that final edge, and they hold steady while the next word is arriving. An active-low clear zeroes the shift register, the counter and every latched output, so reception restarts from the first bit of a new word. Parity only detects an odd number of flipped bits: a word with two corrupted bits passes as clean.

Top module: `sprx_receiver`

## Requirements
- R1: While clr_n is low, data_word, rx_parity, calc_parity, word_valid and parity_err all read 0.
- R2: Bits are sampled on the rising edge of sclk. The first bit received after a word boundary appears on data_word[0], and the seventh appears on data_word[6].
- R3: The eighth bit of each word appears on rx_parity.
- R4: calc_parity equals the exclusive-OR of the seven bits on data_word.
- R5: parity_err is 1 exactly when calc_parity differs from rx_parity for the latched word.
- R6: data_word, rx_parity, parity_err and word_valid change only on the edge that samples the eighth bit of a word. They hold their values while the following word is shifting in.
- R7: word_valid goes to 1 on completion of the first word after a clear and stays 1 until the next clear.
- R8: A clear in the middle of a word discards the bits already taken. The eight bits that follow the release of clr_n form the next word.
- R9: A word with an even number of corrupted bits, including two, is reported with parity_err at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Shift clock; one bit is taken on each rising edge |
| clr_n | input | 1 | Asynchronous active-low clear |
| ser_in | input | 1 | Serial data line |
| data_word | output | 7 | Latched payload of the last complete word, first bit at bit 0 |
| rx_parity | output | 1 | Parity bit received with the last complete word |
| calc_parity | output | 1 | Exclusive-OR of the latched payload bits |
| word_valid | output | 1 | Set once a complete word has been latched since the last clear |
| parity_err | output | 1 | Computed and received parity bits disagree |

## Verification
The bench sends asymmetric payloads, such as a single one in the first or the last position. A receiver that reversed the bit order, or that treated the first bit as parity, would show a mirrored word. Payloads with even and odd numbers of ones, including all zeros and all ones, show whether the parity sense is inverted or computed over the wrong bits. Between word boundaries the bench checks that the outputs hold, which catches a design that exposes the live shift register or latches a bit early. It also clears the receiver partway through a word; a counter that survived the clear would misalign every later word. A word with two flipped bits confirms that the error flag stays low in that case.

// File: rtl/sprx_pkg.sv
package sprx_pkg;
  localparam int MAX_BITS = 64;

  // 1 when the vector holds an odd number of ones
  function automatic logic odd_ones(input logic [MAX_BITS-1:0] v);
    return ^v;
  endfunction

  // disagreement between locally computed and received parity
  function automatic logic par_mismatch(input logic computed, input logic received);
    return computed ^ received;
  endfunction
endpackage

// File: rtl/sprx_shift.sv
module sprx_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              ser_in,
  output logic [WORD_W-1:0] cur_word,
  output logic [WORD_W-1:0] nxt_word
);
  logic [WORD_W-1:0] shreg;

  // shift right: new bit enters at the MSB
  assign nxt_word = {ser_in, shreg[WORD_W-1:1]};
  assign cur_word = shreg;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) shreg <= '0;
    else        shreg <= nxt_word;
  end

  // R2: the MSB always holds the bit sampled on the previous edge
  p_msb_entry_r2: assert property (@(posedge clk) disable iff (!clr_n)
    $past(clr_n) |-> shreg[WORD_W-1] == $past(ser_in));
endmodule

// File: rtl/sprx_bitcnt.sv
module sprx_bitcnt #(
  parameter int WORD_W = 8
) (
  input  logic clk,
  input  logic clr_n,
  output logic word_end
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt;

  assign word_end = (cnt == LAST);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)        cnt <= '0;
    else if (word_end) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R8: the counter never leaves the word range
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!clr_n)
    cnt <= LAST);
  // R8: after a boundary the count restarts from zero
  p_cnt_wrap_r8: assert property (@(posedge clk) disable iff (!clr_n)
    word_end |=> cnt == '0);
endmodule

// File: rtl/sprx_capture.sv
module sprx_capture #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              word_end,
  input  logic [DATA_W:0]   nxt_word,
  output logic [DATA_W-1:0] data_q,
  output logic              par_q,
  output logic              err_q,
  output logic              valid_q
);
  import sprx_pkg::*;

  logic [DATA_W-1:0] payload;
  logic              par_in;
  logic              err_next;

  assign payload  = nxt_word[DATA_W-1:0];
  assign par_in   = nxt_word[DATA_W];
  assign err_next = par_mismatch(odd_ones(MAX_BITS'(payload)), par_in);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      data_q  <= '0;
      par_q   <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (word_end) begin
      data_q  <= payload;
      par_q   <= par_in;
      err_q   <= err_next;
      valid_q <= 1'b1;
    end
  end

  // R6: outputs hold between word boundaries
  p_hold_r6: assert property (@(posedge clk) disable iff (!clr_n)
    !word_end |=> ($stable(data_q) && $stable(par_q) && $stable(err_q)));
  // R7: valid is sticky
  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!clr_n)
    valid_q |=> valid_q);
  // R7: a boundary always leaves a valid word
  p_end_sets_valid_r7: assert property (@(posedge clk) disable iff (!clr_n)
    word_end |=> valid_q);
endmodule

// File: rtl/sprx_receiver.sv
module sprx_receiver #(
  parameter int DATA_W = 7
) (
  input  logic              sclk,
  input  logic              clr_n,
  input  logic              ser_in,
  output logic [DATA_W-1:0] data_word,
  output logic              rx_parity,
  output logic              calc_parity,
  output logic              word_valid,
  output logic              parity_err
);
  import sprx_pkg::*;

  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] nxt_word;
  logic              word_end;

  sprx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (sclk),
    .clr_n    (clr_n),
    .ser_in   (ser_in),
    .cur_word (cur_word),
    .nxt_word (nxt_word)
  );

  sprx_bitcnt #(.WORD_W(WORD_W)) u_cnt (
    .clk      (sclk),
    .clr_n    (clr_n),
    .word_end (word_end)
  );

  sprx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (sclk),
    .clr_n    (clr_n),
    .word_end (word_end),
    .nxt_word (nxt_word),
    .data_q   (data_word),
    .par_q    (rx_parity),
    .err_q    (parity_err),
    .valid_q  (word_valid)
  );

  assign calc_parity = odd_ones(MAX_BITS'(data_word));

  // R5: the latched error flag agrees with the two parity outputs
  p_err_match_r5: assert property (@(posedge sclk) disable iff (!clr_n)
    parity_err == (calc_parity ^ rx_parity));
  // R3: on a boundary the received parity is the bit just taken
  p_parity_bit_r3: assert property (@(posedge sclk) disable iff (!clr_n)
    word_end |=> rx_parity == cur_word[WORD_W-1]);
endmodule

// File: tb/sprx_receiver_test.sv
module sprx_receiver_test;
  logic       sclk = 1'b0;
  logic       clr_n = 1'b1;
  logic       ser_in = 1'b0;
  logic [6:0] data_word;
  logic       rx_parity, calc_parity, word_valid, parity_err;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [6:0] d;
    logic       rp;
    logic       cp;
    logic       e;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_word = 0;

  always #10 sclk = ~sclk;

  sprx_receiver uut (
    .sclk(sclk), .clr_n(clr_n), .ser_in(ser_in),
    .data_word(data_word), .rx_parity(rx_parity), .calc_parity(calc_parity),
    .word_valid(word_valid), .parity_err(parity_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; leaves at a negedge
  task automatic send_word(input logic [6:0] d, input logic rp);
    exp_t it;
    int ones = 0;
    for (int k = 0; k < 7; k++) ones += int'(d[k]);
    it.d  = d;
    it.rp = rp;
    it.cp = (ones % 2 == 1);
    it.e  = (it.cp != rp);
    for (int i = 0; i < 8; i++) begin
      ser_in = (i < 7) ? d[i] : rp;
      if (i == 7) q.push_back(it);
      @(negedge sclk);
    end
  endtask

  task automatic do_clear();
    @(negedge sclk);
    clr_n = 1'b0;
    repeat (2) @(negedge sclk);
    clr_n = 1'b1;
  endtask

  // monitor: samples 5 ns after each rising edge
  always begin
    exp_t it;
    @(posedge sclk);
    #5;
    if (!clr_n) begin
      check(data_word == 7'd0 && !rx_parity && !calc_parity && !word_valid && !parity_err,
            "R1 clear", {data_word, rx_parity, calc_parity, word_valid, parity_err}, 0);
      have_word = 0;
      last = '{default: '0};
      q.delete();
    end else if (q.size() > 0) begin
      it = q.pop_front();
      check(data_word == it.d, "R2 data order", data_word, it.d);
      check(rx_parity == it.rp, "R3 parity bit", rx_parity, it.rp);
      check(calc_parity == it.cp, "R4 computed parity", calc_parity, it.cp);
      check(parity_err == it.e, "R5/R9 error flag", parity_err, it.e);
      check(word_valid == 1'b1, "R7 valid set", word_valid, 1);
      last = it;
      have_word = 1;
    end else begin
      check(data_word == last.d && rx_parity == last.rp && parity_err == last.e,
            "R6 hold", {data_word, rx_parity, parity_err}, {last.d, last.rp, last.e});
      check(word_valid == have_word, "R7/R8 valid level", word_valid, have_word);
    end
  end

  initial begin
    repeat (20000) @(posedge sclk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 clr_n = 1'b0;
    do_clear();
    send_word(7'h01, 1'b1);   // R2: first bit lands at bit 0
    send_word(7'h40, 1'b1);   // R2: seventh bit at bit 6
    send_word(7'h00, 1'b0);   // R4: all zeros
    send_word(7'h7F, 1'b1);   // R4: all ones, odd count
    send_word(7'h55, 1'b0);   // R4: four ones
    send_word(7'h01, 1'b0);   // R5: single error
    send_word(7'h2A, 1'b0);   // R5: three ones, parity wrong
    send_word(7'h56, 1'b0);   // R9: two bits of 0x55 flipped, not detected
    // R8: clear in the middle of a word
    for (int i = 0; i < 3; i++) begin
      ser_in = 1'b1;
      @(negedge sclk);
    end
    do_clear();
    send_word(7'h03, 1'b0);   // R8: aligned word after clear
    send_word(7'h64, 1'b0);   // R5: three ones, parity 0
    repeat (3) @(negedge sclk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule